// File: doc/BRIEF.md
# Two-Hit Row Scanner with Neighbour Marking

This block sits between a row buffer of per-pixel hit flags and the readout multiplexers of a pixel detector front end. The buffer holds one bit per channel for a whole row. The block takes one row from the buffer and scans it on its own, with no external trigger. It drives two channel-select addresses per clock cycle. Each address steers one stored analog value to one of the two readout ports. The block takes the next row only after every flagged channel of the current row has been handed downstream.

A control input can widen the hit set before scanning. When it is set, the left and right neighbours of every pixel whose comparator fired are also read out, even though their own signal stayed below threshold. Only the original hits are widened, so a marked neighbour never marks further pixels. Addresses come out in ascending order, two at a time. An end-of-row flag travels with the final pair. A row counter advances once that final pair has been accepted.

Top module: `hitRowScanner`

## Requirements
- R1: Once a row is accepted (rowValid and rowReady both high at a rising edge), its first output pair appears in the following cycle without any further input. With outReady high, a new pair is issued every cycle.
- R2: Each cycle presents at most two channels. Addresses leave in ascending channel order. When both slots are valid, selAddr1 is strictly greater than selAddr0.
- R3: Slot 1 is never valid unless slot 0 is valid. A single remaining channel always uses slot 0.
- R4: rowReady is high while no row is loaded. While a loaded row still has channels beyond the current pair, rowReady stays low. It rises in the cycle that presents the last pair, and only while outReady is high.
- R5: nbrEn is sampled when the row is accepted. When it is 1, channel c is read out if bit c, bit c-1 or bit c+1 of rowHits is set. Bit index equals channel number. Channel 0 has only channel 1 as a neighbour, and channel 127 has only channel 126.
- R6: Marking uses only the original hit bits. A channel added as a neighbour does not mark its own neighbours.
- R7: A row with no channels to read produces exactly one cycle with rowEnd high and both valids low.
- R8: rowEnd is high together with the last pair of a row. rowIdx starts at 0 and increments by one, modulo 256, in the cycle after rowEnd is accepted with outReady high.
- R9: While outReady is low, the addresses, valids, rowEnd and rowIdx hold their values.
- R10: An active-low reset, which acts at once, forces both valids and rowEnd low, rowReady high and rowIdx to 0, discarding any partly scanned row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowHits | input | 128 | Hit flags of one row, bit c = channel c |
| rowValid | input | 1 | Row buffer has a row available |
| rowReady | output | 1 | Scanner takes the row at this edge |
| nbrEn | input | 1 | Widen each hit to its left and right neighbours |
| selAddr0 | output | 7 | Lower channel address of the current pair |
| selValid0 | output | 1 | selAddr0 is a channel to read |
| selAddr1 | output | 7 | Higher channel address of the current pair |
| selValid1 | output | 1 | selAddr1 is a channel to read |
| rowIdx | output | 8 | Index of the row being scanned |
| rowEnd | output | 1 | Current pair is the last of the row |
| outReady | input | 1 | Downstream takes the current pair at this edge |

## Verification
The properties rely on one assumption about the inputs: rowHits and nbrEn are stable at any edge where rowValid and rowReady are both high. They also rely on outReady being free to change on any cycle. The stall-hold property depends on this. The bench changes its inputs only after a rising edge or at a falling edge. Some rows run with outReady toggling every cycle, so stalls fall both inside rows and on the last pair. One directed case keeps rowValid high with the next row during a scan, and changes nbrEn mid-row, to show that the scanner accepts the new row only when the current one ends.

// File: rtl/hitScanPkg.sv
package hitScanPkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // capture a new (marked) row
    logic advance;  // retire the currently presented pair
  } scanStrobe_t;
endpackage

// File: rtl/lowSetFinder.sv
// Finds the lowest set bit of a vector in two levels: a priority pick
// inside fixed-size groups, then a priority pick across the groups.
module lowSetFinder #(
  parameter int NUM_CH = 128,
  parameter int GRP_W  = 16,
  localparam int ADDR_W = $clog2(NUM_CH),
  localparam int NUM_GRP = NUM_CH / GRP_W,
  localparam int GRP_AW = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
  input  logic [NUM_CH-1:0] vec,
  output logic [ADDR_W-1:0] idx,
  output logic              found
);
  logic [NUM_GRP-1:0] grpFound;
  logic [GRP_AW-1:0]  grpIdx [NUM_GRP];

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) begin
      grpFound[g] = |vec[g*GRP_W +: GRP_W];
      grpIdx[g] = '0;
      for (int j = GRP_W - 1; j >= 0; j--) begin
        if (vec[g*GRP_W + j]) grpIdx[g] = GRP_AW'(j);
      end
    end
    idx = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (grpFound[g]) idx = ADDR_W'(g * GRP_W) + ADDR_W'(grpIdx[g]);
    end
    found = |grpFound;
  end
endmodule

// File: rtl/scanDatapath.sv
module scanDatapath
  import hitScanPkg::*;
#(
  parameter int NUM_CH = 128,
  parameter int GRP_W  = 16,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rowHits,
  input  logic              nbrEn,
  input  scanStrobe_t       strobe,
  output logic [ADDR_W-1:0] addr0,
  output logic [ADDR_W-1:0] addr1,
  output logic              anyHit,
  output logic              twoHits,
  output logic              lastBatch
);
  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  logic [NUM_CH-1:0] marked;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] afterOne;
  logic [NUM_CH-1:0] afterTwo;

  // neighbour widening from the raw hits only; edge channels get one side
  for (genvar c = 0; c < NUM_CH; c++) begin : g_mark
    if (c == 0) begin : g_lo
      assign marked[c] = rowHits[c] | (nbrEn & rowHits[c+1]);
    end else if (c == NUM_CH - 1) begin : g_hi
      assign marked[c] = rowHits[c] | (nbrEn & rowHits[c-1]);
    end else begin : g_mid
      assign marked[c] = rowHits[c] | (nbrEn & (rowHits[c-1] | rowHits[c+1]));
    end
  end

  // strip the lowest one, then the next lowest
  assign afterOne  = pending & (pending - ONE);
  assign afterTwo  = afterOne & (afterOne - ONE);
  assign lastBatch = (afterTwo == '0);

  lowSetFinder #(.NUM_CH(NUM_CH), .GRP_W(GRP_W)) u_first (
    .vec(pending), .idx(addr0), .found(anyHit)
  );
  lowSetFinder #(.NUM_CH(NUM_CH), .GRP_W(GRP_W)) u_second (
    .vec(afterOne), .idx(addr1), .found(twoHits)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pending <= '0;
    else if (strobe.load)   pending <= marked;
    else if (strobe.advance) pending <= afterTwo;
  end
endmodule

// File: rtl/scanControl.sv
module scanControl
  import hitScanPkg::*;
#(
  parameter int ROW_IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rowValid,
  input  logic                 outReady,
  input  logic                 lastBatch,
  output scanStrobe_t          strobe,
  output logic                 busy,
  output logic                 rowReady,
  output logic [ROW_IDX_W-1:0] rowIdx
);
  logic rowDone;

  always_comb begin
    strobe.advance = busy && outReady;
    rowDone        = strobe.advance && lastBatch;
    rowReady       = !busy || rowDone;
    strobe.load    = rowValid && rowReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      rowIdx <= '0;
    end else begin
      if (strobe.load)  busy <= 1'b1;
      else if (rowDone) busy <= 1'b0;
      if (rowDone) rowIdx <= rowIdx + ROW_IDX_W'(1);
    end
  end
endmodule

// File: rtl/hitRowScanner.sv
module hitRowScanner
  import hitScanPkg::*;
#(
  parameter int NUM_CH    = 128,
  parameter int GRP_W     = 16,
  parameter int ROW_IDX_W = 8,
  localparam int ADDR_W   = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CH-1:0]    rowHits,
  input  logic                 rowValid,
  output logic                 rowReady,
  input  logic                 nbrEn,
  output logic [ADDR_W-1:0]    selAddr0,
  output logic                 selValid0,
  output logic [ADDR_W-1:0]    selAddr1,
  output logic                 selValid1,
  output logic [ROW_IDX_W-1:0] rowIdx,
  output logic                 rowEnd,
  input  logic                 outReady
);
  scanStrobe_t strobe;
  logic busy, anyHit, twoHits, lastBatch;

  scanControl #(.ROW_IDX_W(ROW_IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rowValid(rowValid), .outReady(outReady),
    .lastBatch(lastBatch), .strobe(strobe), .busy(busy),
    .rowReady(rowReady), .rowIdx(rowIdx)
  );

  scanDatapath #(.NUM_CH(NUM_CH), .GRP_W(GRP_W)) u_dp (
    .clk(clk), .rstN(rstN), .rowHits(rowHits), .nbrEn(nbrEn),
    .strobe(strobe), .addr0(selAddr0), .addr1(selAddr1),
    .anyHit(anyHit), .twoHits(twoHits), .lastBatch(lastBatch)
  );

  assign selValid0 = busy & anyHit;
  assign selValid1 = busy & twoHits;
  assign rowEnd    = busy & lastBatch;
endmodule

// File: rtl/hitScanChecker.sv
module hitScanChecker #(
  parameter int ADDR_W    = 7,
  parameter int ROW_IDX_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rowValid,
  input logic                 rowReady,
  input logic                 outReady,
  input logic [ADDR_W-1:0]    selAddr0,
  input logic                 selValid0,
  input logic [ADDR_W-1:0]    selAddr1,
  input logic                 selValid1,
  input logic [ROW_IDX_W-1:0] rowIdx,
  input logic                 rowEnd
);
  // R1
  self_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && rowReady) |=> (selValid0 || rowEnd));

  // R2
  ascend_chk: assert property (@(posedge clk) disable iff (!rstN)
    selValid1 |-> (selAddr1 > selAddr0));

  // R3
  slot_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    selValid1 |-> selValid0);

  // R4
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selValid0 && !rowEnd) |-> !rowReady);

  // R4
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(selValid0 || rowEnd) |-> rowReady);

  // R8
  row_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowEnd && outReady) |=> (rowIdx == $past(rowIdx) + ROW_IDX_W'(1)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((selValid0 || rowEnd) && !outReady) |=>
      ($stable(selAddr0) && $stable(selValid0) && $stable(selAddr1) &&
       $stable(selValid1) && $stable(rowEnd) && $stable(rowIdx)));
endmodule

bind hitRowScanner hitScanChecker #(.ADDR_W(ADDR_W), .ROW_IDX_W(ROW_IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .rowValid(rowValid), .rowReady(rowReady),
  .outReady(outReady), .selAddr0(selAddr0), .selValid0(selValid0),
  .selAddr1(selAddr1), .selValid1(selValid1), .rowIdx(rowIdx), .rowEnd(rowEnd)
);

// File: tb/sim_hitRowScanner.sv
`timescale 1ns/1ps
module sim_hitRowScanner;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  // {nbrEn, rowHits}
  localparam logic [128:0] VECS [10] = '{
    {1'b0, 128'h0},                                       // R7 empty
    {1'b0, 128'h8000_0000_0000_0000_0000_0000_0000_0001}, // ends, no marking
    {1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_0001}, // R5 low edge
    {1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_0400}, // R6 single hit 10
    {1'b0, 128'h0000_0000_0000_0000_0000_0000_0000_000F}, // two pairs
    {1'b1, 128'h8000_0000_0000_0000_0000_0000_0000_0001}, // R5 both edges
    {1'b0, {128{1'b1}}},                                  // full row
    {1'b1, {32{4'h5}}},                                   // R5 alternating
    {1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_0030}, // R6 adjacent pair
    {1'b0, 128'h0000_0000_0000_0001_0000_0000_0000_0000}  // lone 64
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] rowHits = '0;
  logic         rowValid = 1'b0;
  logic         rowReady;
  logic         nbrEn = 1'b0;
  logic [6:0]   selAddr0, selAddr1;
  logic         selValid0, selValid1;
  logic [7:0]   rowIdx;
  logic         rowEnd;
  logic         outReady = 1'b1;

  int nChecks = 0;
  int nFail = 0;
  int expRow = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hitRowScanner u0 (
    .clk(clk), .rstN(rstN), .rowHits(rowHits), .rowValid(rowValid),
    .rowReady(rowReady), .nbrEn(nbrEn), .selAddr0(selAddr0),
    .selValid0(selValid0), .selAddr1(selAddr1), .selValid1(selValid1),
    .rowIdx(rowIdx), .rowEnd(rowEnd), .outReady(outReady)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic scanRow(input logic [127:0] h, input bit n, input bit stall);
    int list[128];
    int m = 0;
    int idx = 0;
    int cyc = 0;
    bit done = 0;
    string tag = n ? "R5" : "R2";
    for (int c = 0; c < 128; c++) begin
      bit sel = h[c];
      if (n && c > 0 && h[c-1]) sel = 1;
      if (n && c < 127 && h[c+1]) sel = 1;
      if (sel) begin list[m] = c; m++; end
    end
    @(negedge clk);
    rowHits = h; nbrEn = n; rowValid = 1'b1; outReady = 1'b1;
    while (!rowReady) @(negedge clk);
    @(posedge clk); #1 rowValid = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (stall) outReady = cyc[0];
      cyc++;
      #1;
      chk(selValid0 == (idx < m), m == 0 ? "R7 valid0" : "R3 valid0", selValid0, idx < m);
      if (idx < m) chk(int'(selAddr0) == list[idx], {tag, " addr0"}, selAddr0, list[idx]);
      chk(selValid1 == (idx + 1 < m), "R3 valid1", selValid1, idx + 1 < m);
      if (idx + 1 < m) chk(int'(selAddr1) == list[idx+1], {tag, " addr1"}, selAddr1, list[idx+1]);
      chk(rowEnd == (idx + 2 >= m), stall ? "R9 rowEnd" : "R8 rowEnd", rowEnd, idx + 2 >= m);
      chk(int'(rowIdx) == expRow % 256, stall ? "R9 rowIdx" : "R8 rowIdx", rowIdx, expRow % 256);
      if (outReady) begin
        if (idx + 2 >= m) done = 1;
        idx += 2;
      end
    end
    expRow++;
    outReady = 1'b1;
    @(negedge clk); #1;
    chk(!selValid0 && !rowEnd, "R7 single end cycle", rowEnd, 0);
    chk(rowReady == 1'b1, "R4 idle ready", rowReady, 1);
    chk(int'(rowIdx) == expRow % 256, "R8 rowIdx after end", rowIdx, expRow % 256);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    // R10 reset state
    @(negedge clk); #1;
    chk(!selValid0 && !selValid1 && !rowEnd, "R10 reset valids", selValid0, 0);
    chk(rowReady == 1'b1, "R10 reset ready", rowReady, 1);
    chk(rowIdx == 8'd0, "R10 reset rowIdx", rowIdx, 0);
    @(negedge clk); rstN = 1'b1;

    // table walk, every odd entry with a stalling consumer
    for (int v = 0; v < 10; v++) begin
      scanRow(VECS[v][127:0], VECS[v][128], v[0]);
    end

    // R4 / R1: next row waits during scan, then starts back to back
    @(negedge clk);
    rowHits = (128'h1 << 3) | (128'h1 << 10) | (128'h1 << 20);
    nbrEn = 1'b0; rowValid = 1'b1; outReady = 1'b1;
    @(posedge clk); #1;
    rowHits = 128'h1 << 127; nbrEn = 1'b1;  // R5: new nbrEn must not touch row in flight
    @(negedge clk); #1;
    chk(selAddr0 == 7'd3 && selAddr1 == 7'd10 && selValid1, "R5 in-flight pair", selAddr0, 3);
    chk(rowReady == 1'b0, "R4 hold off", rowReady, 0);
    @(negedge clk); #1;
    chk(selAddr0 == 7'd20 && selValid0 && !selValid1 && rowEnd, "R3 last single", selAddr0, 20);
    chk(rowReady == 1'b1, "R4 ready on last", rowReady, 1);
    @(posedge clk); #1 rowValid = 1'b0;
    @(negedge clk); #1;
    chk(selValid0 && selValid1 && selAddr0 == 7'd126 && selAddr1 == 7'd127,
        "R1 back to back", selAddr0, 126);
    chk(int'(rowIdx) == (expRow + 1) % 256, "R8 rowIdx step", rowIdx, (expRow + 1) % 256);
    chk(rowEnd == 1'b1, "R8 end with last", rowEnd, 1);
    @(posedge clk);
    expRow += 2;
    @(negedge clk); #1;
    chk(int'(rowIdx) == expRow % 256, "R8 rowIdx after pair", rowIdx, expRow % 256);

    // R10: reset in the middle of a long row
    rowHits = {128{1'b1}}; nbrEn = 1'b0; rowValid = 1'b1;
    @(posedge clk); #1 rowValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b0; #1;
    chk(!selValid0 && !selValid1 && !rowEnd, "R10 mid-row reset", selValid0, 0);
    chk(rowReady == 1'b1 && rowIdx == 8'd0, "R10 mid-row reset idle", rowIdx, 0);
    @(negedge clk); rstN = 1'b1;
    expRow = 0;
    scanRow(128'h0000_0000_0000_0000_0000_0000_0000_0022, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule